// File: doc/BRIEF.md
# Delayed Local Multiframe Release

This block derives a per-link local multiframe clock from a multiframe boundary that is already aligned to the system reference. The local clock is a copy of the reference boundary, shifted later by a programmable number of processing-clock cycles. The processing clock runs at one fortieth of the serial lane rate. Words from every lane are held in small per-lane FIFOs. All FIFOs start draining together on the first local boundary after every lane has delivered data. After that point lane word *t* of every lane leaves in the same cycle, which keeps the latency deterministic from link to link.

The controller is a six-state machine:
- `CS_IDLE`: waiting for the first valid word on any lane.
- `CS_GATHER`: the skew window is open and the block waits for the remaining lanes.
- `CS_ARMED`: all lanes are present and the block waits for a local boundary.
- `CS_RUN`: all FIFOs are popped every cycle.
- `CS_ALIGN_FAULT`: absorbing error state.
- `CS_CFG_FAULT`: an illegal setting is present.

Transitions:
- `CS_IDLE` goes to `CS_ARMED` when every lane is valid at once, and to `CS_GATHER` when only some lanes are valid.
- `CS_GATHER` goes to `CS_ARMED` when the last lane arrives, and to `CS_ALIGN_FAULT` when the window expires.
- `CS_ARMED` goes to `CS_RUN` on a local boundary.
- `CS_RUN` goes to `CS_ALIGN_FAULT` when a FIFO runs empty.
- Any working state goes to `CS_ALIGN_FAULT` on a FIFO overflow.
- Any state except `CS_ALIGN_FAULT` goes to `CS_CFG_FAULT` while the registered configuration flag is set.
- `CS_CFG_FAULT` returns to `CS_IDLE` once that flag clears.

Top module: `mf_release`

## Requirements
- R1: While reset is asserted, and right after it, `lmfc_o`, `rd_vld_o`, `rd_data_o`, `cfg_err_o` and `align_err_o` are all zero.
- R2: `cfg_err_o` goes high one clock edge after any of these holds, and is low otherwise:
  - `mf_len_i` < 2;
  - `delay_i` ≥ `mf_len_i`;
  - `var_i` > `mf_len_i`.
- R3: While `cfg_err_o` is high, `lmfc_o` and `rd_vld_o` stay low and the lane FIFOs are emptied.
- R4: `lmfc_o` stays low until the first `ref_mf_i` is sampled. If `ref_mf_i` is sampled high at edge n and no further reference pulse arrives, `lmfc_o` is high for one cycle after each edge n + `delay_i` + j·`mf_len_i`, for j ≥ 0.
- R5: Arming happens at the edge where the last lane is first seen valid. Suppose `lmfc_o` is high after edge m and arming happened at or before edge m, with no earlier such boundary. Then `rd_vld_o` first goes high after edge m+2.
- R6: In the t-th cycle (from 0) that `rd_vld_o` is high, each lane's field holds the t-th valid word written by that lane. Lane l occupies `rd_data_o[l*DATA_W +: DATA_W]`. `rd_vld_o` stays high on consecutive cycles while data keeps arriving.
- R7: Let the first valid word on any lane be sampled at edge e. A lane first seen at edge e+k with k ≤ `var_i` is accepted. If some lane is still missing at edge e+`var_i`+1, `align_err_o` goes high after that edge and no data is released.
- R8: If any lane FIFO is empty at an edge in the releasing state, `rd_vld_o` goes low and `align_err_o` goes high after that same edge.
- R9: A valid word presented to a lane whose FIFO already holds `FIFO_DEPTH` words sets `align_err_o` after that edge.
- R10: Once set, `align_err_o` stays high and `rd_vld_o` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock (lane rate / 40) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_mf_i | input | 1 | One-cycle pulse on each reference-aligned multiframe boundary |
| delay_i | input | CNT_W | Phase delay of the local boundary, in processing clocks |
| var_i | input | CNT_W | Allowed arrival spread across lanes, in processing clocks |
| mf_len_i | input | CNT_W | Processing clocks per multiframe |
| lane_vld_i | input | LANES | Per-lane word valid |
| lane_data_i | input | LANES*DATA_W | Per-lane words, lane l at bits l*DATA_W upward |
| lmfc_o | output | 1 | Local multiframe boundary pulse |
| rd_vld_o | output | 1 | Released words valid on all lanes |
| rd_data_o | output | LANES*DATA_W | Released words, same lane packing as the input |
| cfg_err_o | output | 1 | Illegal delay, variability or period setting |
| align_err_o | output | 1 | Sticky lane skew, underflow or overflow error |

## Verification
The properties assume two things about the inputs:
- Reference pulses are spaced by at least two cycles.
- The settings change only while the block is in reset, or while the change itself drives the block into the configuration fault.

The stimulus follows both rules. Reference pulses come every `mf_len_i` cycles. Each sweep point starts from reset with fixed settings, and the lanes deliver gap-free word streams from staggered start cycles. The only exceptions are the directed underflow and overflow cases, which remove a lane or withhold the boundary on purpose.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_GATHER,
        CS_ARMED,
        CS_RUN,
        CS_ALIGN_FAULT,
        CS_CFG_FAULT
    } mfr_state_e;

endpackage

// File: rtl/mfr_phase_gen.sv
module mfr_phase_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] mf_len_i,
    output logic             lmfc_o
);

    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] phase_d;
    logic             synced_q;
    logic             synced_d;

    always_comb begin
        if (ref_i) begin
            phase_d = '0;
        end else if (phase_q >= mf_len_i - CNT_W'(1)) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + CNT_W'(1);
        end
        synced_d = !hold_i && (synced_q || ref_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            synced_q <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            synced_q <= synced_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lmfc_o <= 1'b0;
        end else begin
            lmfc_o <= synced_d && (phase_d == delay_i);
        end
    end

    // R4
    lmfc_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_o |-> synced_q);

    // R3
    hold_quiets_lmfc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !lmfc_o);

endmodule

// File: rtl/mfr_lane_fifo.sv
module mfr_lane_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = PTR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [OCC_W-1:0]  occ_q;

    assign empty_o   = (occ_q == '0);
    assign full_o    = (occ_q == OCC_W'(DEPTH));
    assign rd_data_o = mem[rd_ptr_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem[wr_ptr_q] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (wr_i) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (rd_i) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            unique case ({wr_i, rd_i})
                2'b10:   occ_q <= occ_q + OCC_W'(1);
                2'b01:   occ_q <= occ_q - OCC_W'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    // R8
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !empty_o);

endmodule

// File: rtl/mfr_ctrl.sv
module mfr_ctrl
    import mfr_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] var_i,
    input  logic [CNT_W-1:0] mf_len_i,
    input  logic [LANES-1:0] lane_vld_i,
    input  logic [LANES-1:0] lane_full_i,
    input  logic [LANES-1:0] lane_empty_i,
    input  logic             lmfc_i,
    output logic             pop_o,
    output logic             flush_o,
    output logic             rd_vld_o,
    output logic             cfg_err_o,
    output logic             align_err_o
);

    localparam int SKEW_W = CNT_W + 1;

    mfr_state_e        state_q;
    mfr_state_e        state_d;
    logic [LANES-1:0]  seen_q;
    logic [SKEW_W-1:0] skew_q;
    logic              cfg_bad;
    logic              all_now;
    logic              any_vld;
    logic              any_empty;
    logic              overflow;
    logic              window_out;

    assign cfg_bad    = (mf_len_i < CNT_W'(2)) || (delay_i >= mf_len_i) ||
                        (var_i > mf_len_i);
    assign all_now    = &(seen_q | lane_vld_i);
    assign any_vld    = |lane_vld_i;
    assign any_empty  = |lane_empty_i;
    assign overflow   = |(lane_vld_i & lane_full_i);
    assign window_out = skew_q > {1'b0, var_i};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (cfg_err_o)      state_d = CS_CFG_FAULT;
                else if (overflow)  state_d = CS_ALIGN_FAULT;
                else if (all_now)   state_d = CS_ARMED;
                else if (any_vld)   state_d = CS_GATHER;
            end
            CS_GATHER: begin
                if (cfg_err_o)       state_d = CS_CFG_FAULT;
                else if (overflow)   state_d = CS_ALIGN_FAULT;
                else if (window_out) state_d = CS_ALIGN_FAULT;
                else if (all_now)    state_d = CS_ARMED;
            end
            CS_ARMED: begin
                if (cfg_err_o)      state_d = CS_CFG_FAULT;
                else if (overflow)  state_d = CS_ALIGN_FAULT;
                else if (lmfc_i)    state_d = CS_RUN;
            end
            CS_RUN: begin
                if (cfg_err_o)                   state_d = CS_CFG_FAULT;
                else if (overflow || any_empty)  state_d = CS_ALIGN_FAULT;
            end
            CS_ALIGN_FAULT: begin
                state_d = CS_ALIGN_FAULT;
            end
            CS_CFG_FAULT: begin
                if (!cfg_err_o)     state_d = CS_IDLE;
            end
            default: begin
                state_d = CS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            seen_q  <= '0;
            skew_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                CS_IDLE: begin
                    seen_q <= seen_q | lane_vld_i;
                    skew_q <= SKEW_W'(1);
                end
                CS_GATHER: begin
                    seen_q <= seen_q | lane_vld_i;
                    if (!(&skew_q)) skew_q <= skew_q + SKEW_W'(1);
                end
                CS_CFG_FAULT: begin
                    seen_q <= '0;
                    skew_q <= '0;
                end
                default: begin
                    seen_q <= seen_q;
                    skew_q <= skew_q;
                end
            endcase
        end
    end

    assign pop_o   = (state_q == CS_RUN) && !any_empty && !cfg_err_o;
    assign flush_o = (state_q == CS_CFG_FAULT) || (state_q == CS_ALIGN_FAULT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err_o   <= 1'b0;
            rd_vld_o    <= 1'b0;
            align_err_o <= 1'b0;
        end else begin
            cfg_err_o   <= cfg_bad;
            rd_vld_o    <= pop_o;
            align_err_o <= (state_d == CS_ALIGN_FAULT);
        end
    end

    // R5
    release_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld_o) |-> $past(lmfc_i, 2));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |=> (align_err_o && !rd_vld_o));

    // R3
    cfg_quiets_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !rd_vld_o);

endmodule

// File: rtl/mf_release.sv
module mf_release #(
    parameter int LANES      = 4,
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_mf_i,
    input  logic [CNT_W-1:0]        delay_i,
    input  logic [CNT_W-1:0]        var_i,
    input  logic [CNT_W-1:0]        mf_len_i,
    input  logic [LANES-1:0]        lane_vld_i,
    input  logic [LANES*DATA_W-1:0] lane_data_i,
    output logic                    lmfc_o,
    output logic                    rd_vld_o,
    output logic [LANES*DATA_W-1:0] rd_data_o,
    output logic                    cfg_err_o,
    output logic                    align_err_o
);

    logic [LANES-1:0] full_w;
    logic [LANES-1:0] empty_w;
    logic             pop_w;
    logic             flush_w;

    mfr_phase_gen #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_i    (ref_mf_i),
        .hold_i   (cfg_err_o),
        .delay_i  (delay_i),
        .mf_len_i (mf_len_i),
        .lmfc_o   (lmfc_o)
    );

    mfr_ctrl #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .delay_i      (delay_i),
        .var_i        (var_i),
        .mf_len_i     (mf_len_i),
        .lane_vld_i   (lane_vld_i),
        .lane_full_i  (full_w),
        .lane_empty_i (empty_w),
        .lmfc_i       (lmfc_o),
        .pop_o        (pop_w),
        .flush_o      (flush_w),
        .rd_vld_o     (rd_vld_o),
        .cfg_err_o    (cfg_err_o),
        .align_err_o  (align_err_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] head_w;
        logic              wr_w;

        assign wr_w = lane_vld_i[g] && !full_w[g] && !flush_w;

        mfr_lane_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_i   (flush_w),
            .wr_i      (wr_w),
            .wr_data_i (lane_data_i[g*DATA_W +: DATA_W]),
            .rd_i      (pop_w),
            .rd_data_o (head_w),
            .empty_o   (empty_w[g]),
            .full_o    (full_w[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data_o[g*DATA_W +: DATA_W] <= '0;
            end else begin
                rd_data_o[g*DATA_W +: DATA_W] <= pop_w ? head_w : '0;
            end
        end
    end

endmodule

// File: tb/mf_release_tb.sv
module mf_release_tb;

    localparam int LANES = 4;
    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int CW    = 8;
    localparam int S     = 3;
    localparam int NEVER = 1000000;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 ref_mf;
    logic [CW-1:0]        delay_s;
    logic [CW-1:0]        var_s;
    logic [CW-1:0]        mf_len_s;
    logic [LANES-1:0]     vld;
    logic [LANES*DW-1:0]  din;
    logic                 lmfc;
    logic                 rvld;
    logic [LANES*DW-1:0]  rdata;
    logic                 cfg_err;
    logic                 al_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mf_release #(
        .LANES      (LANES),
        .DATA_W     (DW),
        .FIFO_DEPTH (DEPTH),
        .CNT_W      (CW)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_mf_i    (ref_mf),
        .delay_i     (delay_s),
        .var_i       (var_s),
        .mf_len_i    (mf_len_s),
        .lane_vld_i  (vld),
        .lane_data_i (din),
        .lmfc_o      (lmfc),
        .rd_vld_o    (rvld),
        .rd_data_o   (rdata),
        .cfg_err_o   (cfg_err),
        .align_err_o (al_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit lm_at(input int k, input int mf, input int dly);
        return (k - dly >= mf) && ((k - dly) % mf == 0);
    endfunction

    task automatic do_reset(input int mf, input int dly, input int vr);
        mf_len_s = CW'(mf);
        delay_s  = CW'(dly);
        var_s    = CW'(vr);
        rst_n    = 1'b0;
        ref_mf   = 1'b0;
        vld      = '0;
        din      = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 lmfc", int'(lmfc), 0);
        check("R1 rd_vld", int'(rvld), 0);
        check("R1 rd_data", int'(rdata != '0), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        check("R1 align_err", int'(al_err), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_case(input int mf, input int dly, input int vr, input int skew,
                            input int stop_lane, input int stop_at, input int n);
        int a_edge;
        int m_edge;
        int f_edge;
        bit skew_bad;
        do_reset(mf, dly, vr);
        skew_bad = (skew * (LANES - 1) > vr);
        f_edge   = skew_bad ? S + vr + 1 : NEVER;
        a_edge   = S + skew * (LANES - 1);
        m_edge   = a_edge;
        while (!lm_at(m_edge, mf, dly)) m_edge++;
        if (!skew_bad && stop_lane >= 0)
            f_edge = (stop_at - (S + stop_lane * skew)) + m_edge + 2;
        for (int k = 1; k <= n; k++) begin
            ref_mf = (k % mf == 0);
            for (int l = 0; l < LANES; l++) begin
                int st;
                bit v;
                st = S + l * skew;
                v  = (k >= st) && !(l == stop_lane && k >= stop_at);
                vld[l] = v;
                din[l*DW +: DW] = v ? {8'(l), 8'(k - st)} : '0;
            end
            @(posedge clk);
            @(negedge clk);
            // R4 local boundary position
            check("R4 lmfc", int'(lmfc), int'(lm_at(k, mf, dly)));
            // R2 legal settings
            check("R2 cfg_err", int'(cfg_err), 0);
            if (stop_lane >= 0) begin
                // R8 underflow
                check("R8 align_err", int'(al_err), int'(k >= f_edge));
            end else begin
                // R7 skew window, R10 sticky
                check("R7 align_err", int'(al_err), int'(k >= f_edge));
            end
            if (!skew_bad && k >= m_edge + 2 && k < f_edge) begin
                // R5 release start
                check("R5 rd_vld", int'(rvld), 1);
                for (int l = 0; l < LANES; l++) begin
                    // R6 aligned words across lanes
                    check("R6 lane word", int'(rdata[l*DW +: DW]),
                          int'({8'(l), 8'(k - m_edge - 2)}));
                end
            end else begin
                // R5 and R10 idle read side
                check("R5 rd_vld idle", int'(rvld), 0);
            end
        end
    endtask

    initial begin
        int vr;
        // sweep over period, delay and lane skew
        for (int mi = 0; mi < 3; mi++) begin
            int mf;
            mf = 4 << mi;
            vr = (mf < 12) ? mf : 12;
            for (int di = 0; di < 3; di++) begin
                int dly;
                dly = (di == 0) ? 0 : ((di == 1) ? mf / 2 : mf - 1);
                for (int sk = 0; sk < 4; sk++) begin
                    run_case(mf, dly, vr, sk, -1, 0, 70);
                end
            end
        end

        // R8 lane 2 stops delivering after release
        run_case(8, 0, 8, 0, 2, 40, 80);
        run_case(8, 3, 8, 1, 1, 45, 80);

        // R9 overflow: no reference, FIFOs fill up
        do_reset(8, 0, 4);
        for (int k = 1; k <= S + 34; k++) begin
            vld = {LANES{k >= S}};
            for (int l = 0; l < LANES; l++) din[l*DW +: DW] = DW'(k);
            @(posedge clk);
            @(negedge clk);
            check("R9 align_err", int'(al_err), int'(k >= S + DEPTH));
            check("R4 no lmfc without ref", int'(lmfc), 0);
        end

        // R2 and R3: illegal settings
        for (int c = 0; c < 4; c++) begin
            int mf;
            int dly;
            mf  = (c == 0) ? 1 : ((c == 3) ? 0 : 8);
            dly = (c == 1) ? 8 : ((c == 2) ? 2 : 0);
            vr  = (c == 2) ? 9 : 0;
            do_reset(mf, dly, vr);
            for (int k = 1; k <= 30; k++) begin
                ref_mf = (k % 4 == 0);
                vld    = {LANES{k >= S}};
                din    = '1;
                @(posedge clk);
                @(negedge clk);
                check("R2 cfg_err", int'(cfg_err), 1);
                check("R3 lmfc quiet", int'(lmfc), 0);
                check("R3 rd_vld quiet", int'(rvld), 0);
            end
        end

        // R2 upper-edge legal setting: delay = period-1, variability = period
        do_reset(6, 5, 6);
        for (int k = 1; k <= 20; k++) begin
            ref_mf = (k % 6 == 0);
            vld    = '0;
            @(posedge clk);
            @(negedge clk);
            check("R2 edge legal", int'(cfg_err), 0);
            check("R4 edge lmfc", int'(lmfc), int'(lm_at(k, 6, 5)));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule